// File: doc/BRIEF.md
# Split-Mode Auto-Reload Timer with Comparator Capture

This block is a counter peripheral on a byte-wide register bus. In its default arrangement the two count bytes form one 16-bit counter. On overflow the counter reloads from a 16-bit reload pair. With the split bit set, the bytes become two separate 8-bit counters, and each reloads from its own reload byte. In split mode the low byte always counts, while the run bit starts and stops only the high byte.

Each byte counts on a tick taken from one of two sources. The shared source is the system clock divided by twelve, or the rising edges of an external clock divided by eight. A per-byte input can bypass that source and count every system clock. When capture is enabled, a rising edge on the comparator input copies the live count into the reload pair and raises the high flag. During capture the counter wraps to zero instead of reloading, so captured values are not overwritten. Both flags are sticky. The interrupt output combines them with an external timer interrupt enable.

Top module: `split_reload_timer`

## Requirements
- R1: After reset, every register reads 0x00, and both flags and the interrupt output are 0.
- R2: The control register holds, from bit 7 to bit 0: high flag, low flag, low-flag interrupt enable, capture enable, split, run, a bit that always reads 0 and ignores writes, and source select.
- R3: With split clear and run set, a count of 0xFFFF advances to the reload pair (high byte at address 4, low byte at address 3) and sets the high flag. When capture enable is 0, the count keeps reloading this way.
- R4: The low flag sets whenever the low count byte passes 0xFF, in either mode. This includes a 16-bit carry such as 0x00FF to 0x0100, which leaves the high flag clear.
- R5: With split set, a byte at 0xFF advances to its own reload byte and sets its own flag.
- R6: With split set, the high byte holds while run is 0, and the low byte counts whatever the state of run.
- R7: Hardware only ever sets a flag. A flag falls only when a control write carries 0 in its position.
- R8: One cycle after the flags change, the interrupt output equals the timer interrupt enable ANDed with (high flag OR (low enable AND low flag)).
- R9: With capture enable set, a rising comparator edge copies the count into the reload pair and sets the high flag. With capture enable clear, the edge changes nothing.
- R10: While capture enable is set, an overflowing counter wraps to 0x00 instead of loading the reload value.
- R11: When source select is 0, a byte counts once per 12 system clocks. When it is 1, a byte counts once per 8 external rising edges. A byte whose fast input is 1 counts on every system clock.
- R12: A read returns data one cycle after the request. The addresses are: 0 control, 1 count low, 2 count high, 3 reload low, 4 reload high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_i | input | 1 | Asynchronous external count clock |
| cmp_i | input | 1 | Asynchronous comparator output |
| lo_fast_i | input | 1 | Low byte counts every system clock when 1 |
| hi_fast_i | input | 1 | High byte counts every system clock when 1 |
| tmr_ien_i | input | 1 | Timer interrupt enable from the interrupt controller |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | BYTE_W | Write data |
| bus_rdata_o | output | BYTE_W | Registered read data |
| flag_hi_o | output | 1 | High overflow / capture flag |
| flag_lo_o | output | 1 | Low byte overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench aims at the 0xFFFF edge. A design that loads zero there would miss the reload pair, and a design that skips the low flag on the full overflow would be caught there too. It checks that a carry from 0x00FF raises only the low flag, which exposes a design that sets the high flag on every low wrap. In split mode it holds run at 0 for hundreds of cycles and reads the high byte back, which catches a design that lets run gate the low byte or fails to freeze the high byte. For capture, the bench checks three cases: a disabled capture that would corrupt the reload pair, an overflow that reloads instead of wrapping freely, and prescaler counts that drift from exactly one tick per 12 system clocks or per 8 external edges.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_CNT_LO = 3'd1,
    A_CNT_HI = 3'd2,
    A_RLD_LO = 3'd3,
    A_RLD_HI = 3'd4
  } srt_addr_e;

  localparam int B_FHI  = 7;
  localparam int B_FLO  = 6;
  localparam int B_LIEN = 5;
  localparam int B_CAP  = 4;
  localparam int B_SPL  = 3;
  localparam int B_RUN  = 2;
  localparam int B_SRC  = 0;
endpackage

// File: rtl/srt_sync_edge.sv
module srt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = async_i;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], async_i};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/srt_tick_div.sv
module srt_tick_div #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic tick_o
);
  localparam int            CW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/srt_count_core.sv
module srt_count_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         split_i,
  input  logic         run_i,
  input  logic         free_i,
  input  logic         tick_lo_i,
  input  logic         tick_hi_i,
  input  logic [W-1:0] rld_lo_i,
  input  logic [W-1:0] rld_hi_i,
  input  logic         wr_lo_i,
  input  logic         wr_hi_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_lo_o,
  output logic [W-1:0] cnt_hi_o,
  output logic         wrap_lo_o,
  output logic         wrap_hi_o
);
  logic en16, en_lo, en_hi8, lo_max, hi_max, lo_reload;
  logic [W-1:0] lo_base, hi_base;

  assign lo_max    = &cnt_lo_o;
  assign hi_max    = &cnt_hi_o;
  assign en16      = !split_i && run_i && tick_lo_i;
  assign en_lo     = split_i ? tick_lo_i : en16;
  assign en_hi8    = split_i && run_i && tick_hi_i;
  assign lo_reload = split_i ? lo_max : (lo_max && hi_max);
  assign lo_base   = free_i ? '0 : rld_lo_i;
  assign hi_base   = free_i ? '0 : rld_hi_i;

  assign wrap_lo_o = en_lo && lo_max;
  assign wrap_hi_o = split_i ? (en_hi8 && hi_max) : (en16 && lo_max && hi_max);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_lo_o <= '0;
    end else if (wr_lo_i) begin
      cnt_lo_o <= wdata_i;
    end else if (en_lo) begin
      cnt_lo_o <= lo_reload ? lo_base : cnt_lo_o + W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_hi_o <= '0;
    end else if (wr_hi_i) begin
      cnt_hi_o <= wdata_i;
    end else if (split_i ? en_hi8 : (en16 && lo_max)) begin
      cnt_hi_o <= hi_max ? hi_base : cnt_hi_o + W'(1);
    end
  end
endmodule

// File: rtl/split_reload_timer.sv
module split_reload_timer
  import srt_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYS_DIV     = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_clk_i,
  input  logic              cmp_i,
  input  logic              lo_fast_i,
  input  logic              hi_fast_i,
  input  logic              tmr_ien_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [2:0]        bus_addr_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  output logic              flag_hi_o,
  output logic              flag_lo_o,
  output logic              irq_o
);
  localparam int CNT_W = 2 * BYTE_W;

  logic flag_hi, flag_lo, lo_ien, cap_en, split, run, src_ext;
  logic [BYTE_W-1:0] rld_lo, rld_hi, cnt_lo, cnt_hi;
  logic [CNT_W-1:0]  cnt_full;
  logic wrap_lo, wrap_hi;
  logic sys_tick, ext_rise, ext_tick, cmp_rise, cap_evt, src_tick;
  logic wr_ctrl, wr_clo, wr_chi, wr_rlo, wr_rhi;

  assign wr_ctrl = bus_wr_i && (bus_addr_i == A_CTRL);
  assign wr_clo  = bus_wr_i && (bus_addr_i == A_CNT_LO);
  assign wr_chi  = bus_wr_i && (bus_addr_i == A_CNT_HI);
  assign wr_rlo  = bus_wr_i && (bus_addr_i == A_RLD_LO);
  assign wr_rhi  = bus_wr_i && (bus_addr_i == A_RLD_HI);

  srt_tick_div #(.DIV(SYS_DIV)) u_sys_div (
    .clk(clk), .rst(rst), .en_i(1'b1), .tick_o(sys_tick)
  );

  srt_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst(rst), .async_i(ext_clk_i), .rise_o(ext_rise)
  );

  srt_tick_div #(.DIV(EXT_DIV)) u_ext_div (
    .clk(clk), .rst(rst), .en_i(ext_rise), .tick_o(ext_tick)
  );

  srt_sync_edge #(.STAGES(SYNC_STAGES)) u_cmp_sync (
    .clk(clk), .rst(rst), .async_i(cmp_i), .rise_o(cmp_rise)
  );

  assign src_tick = src_ext ? ext_tick : sys_tick;
  assign cap_evt  = cmp_rise && cap_en;

  srt_count_core #(.W(BYTE_W)) u_core (
    .clk(clk), .rst(rst),
    .split_i(split), .run_i(run), .free_i(cap_en),
    .tick_lo_i(lo_fast_i | src_tick), .tick_hi_i(hi_fast_i | src_tick),
    .rld_lo_i(rld_lo), .rld_hi_i(rld_hi),
    .wr_lo_i(wr_clo), .wr_hi_i(wr_chi), .wdata_i(bus_wdata_i),
    .cnt_lo_o(cnt_lo), .cnt_hi_o(cnt_hi),
    .wrap_lo_o(wrap_lo), .wrap_hi_o(wrap_hi)
  );

  assign cnt_full = {cnt_hi, cnt_lo};

  // control fields and sticky flags
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_hi <= 1'b0;
      flag_lo <= 1'b0;
      lo_ien  <= 1'b0;
      cap_en  <= 1'b0;
      split   <= 1'b0;
      run     <= 1'b0;
      src_ext <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        flag_hi <= bus_wdata_i[B_FHI] | wrap_hi | cap_evt;
        flag_lo <= bus_wdata_i[B_FLO] | wrap_lo;
        lo_ien  <= bus_wdata_i[B_LIEN];
        cap_en  <= bus_wdata_i[B_CAP];
        split   <= bus_wdata_i[B_SPL];
        run     <= bus_wdata_i[B_RUN];
        src_ext <= bus_wdata_i[B_SRC];
      end else begin
        flag_hi <= flag_hi | wrap_hi | cap_evt;
        flag_lo <= flag_lo | wrap_lo;
      end
    end
  end

  // reload pair: capture has priority over bus writes
  always_ff @(posedge clk) begin
    if (rst) begin
      rld_lo <= '0;
      rld_hi <= '0;
    end else if (cap_evt) begin
      rld_lo <= cnt_full[BYTE_W-1:0];
      rld_hi <= cnt_full[CNT_W-1:BYTE_W];
    end else begin
      if (wr_rlo) rld_lo <= bus_wdata_i;
      if (wr_rhi) rld_hi <= bus_wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o <= '0;
    end else if (bus_rd_i) begin
      case (bus_addr_i)
        A_CTRL:   bus_rdata_o <= BYTE_W'({flag_hi, flag_lo, lo_ien, cap_en,
                                          split, run, 1'b0, src_ext});
        A_CNT_LO: bus_rdata_o <= cnt_lo;
        A_CNT_HI: bus_rdata_o <= cnt_hi;
        A_RLD_LO: bus_rdata_o <= rld_lo;
        A_RLD_HI: bus_rdata_o <= rld_hi;
        default:  bus_rdata_o <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= tmr_ien_i & (flag_hi | (lo_ien & flag_lo));
  end

  assign flag_hi_o = flag_hi;
  assign flag_lo_o = flag_lo;
endmodule

// File: rtl/srt_checker.sv
module srt_checker
  import srt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [2:0]        bus_addr_i,
  input logic [BYTE_W-1:0] bus_rdata_o,
  input logic              flag_hi_o,
  input logic              flag_lo_o,
  input logic              irq_o,
  input logic              tmr_ien_i,
  input logic              lo_ien,
  input logic              cap_en,
  input logic              split,
  input logic              run,
  input logic [BYTE_W-1:0] cnt_hi,
  input logic [BYTE_W-1:0] rld_lo,
  input logic [BYTE_W-1:0] rld_hi
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  // R7: flags are sticky without a control write
  a_r7_hi_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_hi_o && !(bus_wr_i && bus_addr_i == A_CTRL)) |=> flag_hi_o);
  a_r7_lo_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_lo_o && !(bus_wr_i && bus_addr_i == A_CTRL)) |=> flag_lo_o);

  // R2: bit 1 of the control readback is always zero
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && bus_addr_i == A_CTRL) |=> !bus_rdata_o[1]);

  // R6: high byte frozen in split mode while stopped
  a_r6_hi_frozen: assert property (@(posedge clk) disable iff (rst)
    (split && !run && !(bus_wr_i && bus_addr_i == A_CNT_HI))
      |=> (cnt_hi == $past(cnt_hi)));

  // R9: reload pair untouched without capture enable or a bus write
  a_r9_no_capture: assert property (@(posedge clk) disable iff (rst)
    (!cap_en && !(bus_wr_i && (bus_addr_i == A_RLD_LO || bus_addr_i == A_RLD_HI)))
      |=> ({rld_hi, rld_lo} == $past({rld_hi, rld_lo})));

  // R8: interrupt follows flags and enables one cycle later
  a_r8_irq_follow: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (irq_o == $past(tmr_ien_i & (flag_hi_o | (lo_ien & flag_lo_o)))));
endmodule

bind split_reload_timer srt_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
  .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o),
  .flag_hi_o(flag_hi_o), .flag_lo_o(flag_lo_o), .irq_o(irq_o),
  .tmr_ien_i(tmr_ien_i), .lo_ien(lo_ien), .cap_en(cap_en),
  .split(split), .run(run), .cnt_hi(cnt_hi), .rld_lo(rld_lo), .rld_hi(rld_hi)
);

// File: tb/test_split_reload_timer.sv
`timescale 1ns/1ps
module test_split_reload_timer;
  import srt_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_clk = 1'b0, cmp = 1'b0;
  logic lo_fast = 1'b1, hi_fast = 1'b1, tmr_ien = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic flag_hi, flag_lo, irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  split_reload_timer i_split_reload_timer (
    .clk(clk), .rst(rst), .ext_clk_i(ext_clk), .cmp_i(cmp),
    .lo_fast_i(lo_fast), .hi_fast_i(hi_fast), .tmr_ien_i(tmr_ien),
    .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .flag_hi_o(flag_hi), .flag_lo_o(flag_lo), .irq_o(irq)
  );

  typedef struct {
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb_q[$];
  item_t mon_item;
  logic  rd_d = 1'b0;

  always @(posedge clk) rd_d <= bus_rd;

  // monitor: compares registered read data one cycle after the request
  always @(negedge clk) begin
    if (rd_d) begin
      total++;
      if (sb_q.size() == 0) begin
        bad++;
        $display("FAIL R12 unexpected read data act=%02h exp=none", bus_rdata);
      end else begin
        mon_item = sb_q.pop_front();
        if (bus_rdata !== mon_item.exp) begin
          bad++;
          $display("FAIL %s act=%02h exp=%02h", mon_item.req, bus_rdata, mon_item.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string req);
    item_t it;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    it.exp = e; it.req = req;
    sb_q.push_back(it);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic act, input logic e, input string req);
    @(negedge clk);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", req, act, e);
    end
  endtask

  task automatic pulse_cmp();
    @(negedge clk); cmp = 1'b1;
    repeat (4) @(negedge clk);
    cmp = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 / R12: reset values across the register map
    rd(A_CTRL,   8'h00, "R1 ctrl reset");
    rd(A_CNT_LO, 8'h00, "R1 cnt_lo reset");
    rd(A_CNT_HI, 8'h00, "R1 cnt_hi reset");
    rd(A_RLD_LO, 8'h00, "R12 rld_lo reset");
    rd(A_RLD_HI, 8'h00, "R12 rld_hi reset");
    chk(flag_hi, 1'b0, "R1 flag_hi");
    chk(irq, 1'b0, "R1 irq");

    // R2: unused bit ignored, other fields read back in place
    wr(A_CTRL, 8'h02);
    rd(A_CTRL, 8'h00, "R2 unused bit");
    wr(A_CTRL, 8'h29);
    rd(A_CTRL, 8'h29, "R2 field layout");
    wr(A_CTRL, 8'h00);

    // R3: 16-bit overflow loads reload pair, sets both flags
    wr(A_RLD_LO, 8'h34); wr(A_RLD_HI, 8'h12);
    wr(A_CNT_LO, 8'hFE); wr(A_CNT_HI, 8'hFF);
    wr(A_CTRL, 8'h04);
    idle(1);
    wr(A_CTRL, 8'hC0);
    rd(A_CNT_LO, 8'h34, "R3 reload lo");
    rd(A_CNT_HI, 8'h12, "R3 reload hi");
    rd(A_CTRL,   8'hC0, "R3 flags");
    idle(2);
    chk(flag_hi, 1'b1, "R7 hi flag held");
    chk(irq, 1'b1, "R8 irq from hi flag");
    wr(A_CTRL, 8'h00);
    idle(2);
    chk(flag_hi, 1'b0, "R7 hi flag cleared by write");
    chk(irq, 1'b0, "R8 irq drops");

    // R4: carry 0x00FF -> 0x0100 raises only the low flag
    wr(A_CNT_LO, 8'hFF); wr(A_CNT_HI, 8'h00);
    wr(A_CTRL, 8'h04);
    wr(A_CTRL, 8'h00);
    rd(A_CNT_LO, 8'h00, "R4 carry lo");
    rd(A_CNT_HI, 8'h01, "R4 carry hi");
    rd(A_CTRL,   8'h40, "R4 only low flag");
    idle(2);
    chk(irq, 1'b0, "R8 low flag masked");
    wr(A_CTRL, 8'h60);
    idle(2);
    chk(irq, 1'b1, "R8 low flag enabled");
    tmr_ien = 1'b0;
    idle(2);
    chk(irq, 1'b0, "R8 timer enable off");
    tmr_ien = 1'b1;
    wr(A_CTRL, 8'h00);

    // R5 / R6: split mode
    wr(A_RLD_LO, 8'hF0); wr(A_RLD_HI, 8'h80);
    wr(A_CNT_HI, 8'hFF);
    wr(A_CTRL, 8'h08);
    idle(300);
    rd(A_CNT_HI, 8'hFF, "R6 hi frozen without run");
    chk(flag_lo, 1'b1, "R6 low byte runs without run");
    chk(flag_hi, 1'b0, "R6 no hi flag while stopped");
    wr(A_CNT_LO, 8'hFE);
    idle(2);
    rd(A_CNT_LO, 8'hF0, "R5 low byte own reload");
    wr(A_CTRL, 8'h0C);
    idle(1);
    rd(A_CNT_HI, 8'h80, "R5 high byte own reload");
    chk(flag_hi, 1'b1, "R5 high flag in split");
    wr(A_CTRL, 8'h00);

    // R11: high byte on sysclk/12 in split mode
    hi_fast = 1'b0;
    wr(A_CTRL, 8'h08);
    wr(A_CNT_HI, 8'h00);
    wr(A_CTRL, 8'h0C);
    idle(119);
    wr(A_CTRL, 8'h08);
    rd(A_CNT_HI, 8'h0A, "R11 sysclk div12");
    hi_fast = 1'b1;
    wr(A_CTRL, 8'h00);

    // R11: external clock divided by 8
    lo_fast = 1'b0;
    wr(A_CNT_LO, 8'h00); wr(A_CNT_HI, 8'h00);
    wr(A_CTRL, 8'h05);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk); ext_clk = 1'b1;
      repeat (3) @(negedge clk);
      ext_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
    idle(6);
    wr(A_CTRL, 8'h01);
    rd(A_CNT_LO, 8'h0A, "R11 ext div8 lo");
    rd(A_CNT_HI, 8'h00, "R11 ext div8 hi");
    lo_fast = 1'b1;
    wr(A_CTRL, 8'h00);

    // R9: capture on comparator edge
    wr(A_CNT_LO, 8'hCD); wr(A_CNT_HI, 8'hAB);
    wr(A_CTRL, 8'h10);
    pulse_cmp();
    idle(6);
    rd(A_RLD_LO, 8'hCD, "R9 capture lo");
    rd(A_RLD_HI, 8'hAB, "R9 capture hi");
    rd(A_CTRL,   8'h90, "R9 capture flag");
    wr(A_CTRL, 8'h00);
    wr(A_CNT_LO, 8'h11);
    pulse_cmp();
    idle(6);
    rd(A_RLD_LO, 8'hCD, "R9 capture disabled");
    rd(A_CTRL,   8'h00, "R9 no flag when disabled");

    // R10: free wrap while capture enabled
    wr(A_CNT_LO, 8'hFF); wr(A_CNT_HI, 8'hFF);
    wr(A_CTRL, 8'h14);
    wr(A_CTRL, 8'h90);
    rd(A_CNT_LO, 8'h00, "R10 wrap lo");
    rd(A_CNT_HI, 8'h00, "R10 wrap hi");
    rd(A_CTRL,   8'hD0, "R10 flags on wrap");
    rd(A_RLD_HI, 8'hAB, "R10 reload kept");

    idle(3);
    if (sb_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R12 pending reads act=%0d exp=0", sb_q.size());
    end
    finish_run();
  end
endmodule